// File: doc/BRIEF.md
# Hit Address Synchronizer and Serial Link Encoder

This block sits between a row of asynchronous hit comparators and a set of serial output lines. Each comparator level is brought into the bit-clock domain through a two-stage synchronizer. At each frame boundary the synchronized level is sampled. A pixel whose sampled level is high now and was low at the previous boundary counts as one new hit for that frame.

The new hits of a frame are ranked by pixel index. The lowest-index hit is encoded for link 0 and the next one for link 1. Any further hits in that frame are discarded. Each link frame is FRAME_W = ADDR_W + 2 bits wide and holds the pixel address, a hit flag and an even parity bit. The parity bit is built by a chain of XOR stages, each with a parity input and a parity output.

A single bit clock `clk_i` drives the whole block. An internal divide-by-FRAME_W phase counter marks the frame boundaries, so the frame rate is one eighth of the bit rate with the default sizes. On a boundary edge every link shift register loads its new frame. On the other edges it shifts left, so each frame leaves most significant bit first, exactly one frame per frame period.

Top module: `hit_link_serializer`

## Requirements
- R1: A comparator level that rises between two frame boundaries yields exactly one hit, in the frame that follows the boundary that first samples it high. A level still held high at later boundaries yields no further hit.
- R2: A frame is sent MSB first over FRAME_W consecutive bit-clock cycles. The bit order is: the address from bit ADDR_W-1 down to bit 0, then the hit flag, then the parity bit. The address is the pixel index.
- R3: The parity bit makes the count of ones across the address bits, the hit bit and the parity bit even.
- R4: When two or more new hits share a frame, the lowest pixel index goes on link 0 and the second-lowest goes on link 1.
- R5: New hits beyond the number of links in one frame are dropped, and none of them appears in any later frame.
- R6: A link with no hit to send outputs an all-zero frame, with the hit bit at 0 and the parity bit at 0.
- R7: Boundary edges fall at bit-clock edges FRAME_W, 2·FRAME_W, and so on, counted after reset release. A frame loaded at boundary k carries the hits that were detected at boundary k-1.
- R8: While rst_ni is low, every serial output is 0.
- R9: When a frame holds exactly one new hit, link 1 sends the idle frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; the frame rate is this clock divided by FRAME_W |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hit_i | input | N_PIX | Asynchronous comparator levels, one per pixel |
| link_o | output | N_LINKS | Serial data lines, one per link |

## Verification
The bench first sweeps a single hit across all 64 pixels. This catches a swapped address, a misplaced field, odd parity, or link 1 carrying a copy of link 0. Mirrored pixel pairs then test the ranking of the two links. A design with the priority reversed would put the high index on link 0.

Triples and an all-pixels burst test the dropping of surplus hits. A design that queues the extras would leak them into later frames, which must stay idle. Levels held high across several boundaries, plus a second pixel rising while a first one stays high, test that a hit is an edge and not a level. A level-driven design would repeat the held pixel in every frame. Every frame in the run is deserialized and compared, so a one-cycle slip in the load phase or a one-frame latency error breaks every frame.

// File: rtl/hitser_pkg.sv
package hitser_pkg;
  localparam int unsigned DEF_N_PIX   = 64;
  localparam int unsigned DEF_N_LINKS = 2;
endpackage

// File: rtl/hitser_phase.sv
module hitser_phase #(
  parameter int unsigned FRAME_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == CNT_W'(FRAME_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // boundary strobe is never back to back
  assert_tick_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/hitser_edge_sync.sv
module hitser_edge_sync #(
  parameter int unsigned N_PIX = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [N_PIX-1:0] lvl_i,
  output logic [N_PIX-1:0] edge_o
);
  logic [N_PIX-1:0] meta_q, sync_q, samp_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= lvl_i;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      prev_q <= '0;
    end else if (tick_i) begin
      samp_q <= sync_q;
      prev_q <= samp_q;
    end
  end

  assign edge_o = samp_q & ~prev_q;

  // hit vector only moves on a frame boundary
  assert_edge_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(edge_o));
endmodule

// File: rtl/hitser_par_stage.sv
module hitser_par_stage (
  input  logic par_i,
  input  logic bit_i,
  output logic par_o
);
  assign par_o = par_i ^ bit_i;
endmodule

// File: rtl/hitser_encoder.sv
module hitser_encoder #(
  parameter int unsigned N_PIX   = 64,
  parameter int unsigned N_LINKS = 2,
  parameter int unsigned ADDR_W  = $clog2(N_PIX),
  parameter int unsigned FRAME_W = ADDR_W + 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N_PIX-1:0]                 hits_i,
  output logic [N_LINKS-1:0][FRAME_W-1:0]  frame_o
);
  logic [ADDR_W-1:0] addr_sel [N_LINKS];
  logic [N_LINKS-1:0] hit_sel;
  logic [N_PIX-1:0]   rem;
  logic               found;

  // lowest remaining index per link, consumed in link order
  always_comb begin
    rem     = hits_i;
    hit_sel = '0;
    for (int l = 0; l < N_LINKS; l++) begin
      found       = 1'b0;
      addr_sel[l] = '0;
      for (int i = 0; i < N_PIX; i++) begin
        if (rem[i] && !found) begin
          found       = 1'b1;
          addr_sel[l] = ADDR_W'(i);
        end
      end
      hit_sel[l] = found;
      if (found) rem[addr_sel[l]] = 1'b0;
    end
  end

  for (genvar l = 0; l < N_LINKS; l++) begin : g_link
    logic [ADDR_W:0] chain;
    assign chain[0] = hit_sel[l];
    for (genvar k = 0; k < ADDR_W; k++) begin : g_stage
      hitser_par_stage i_stage (
        .par_i (chain[k]),
        .bit_i (addr_sel[l][k]),
        .par_o (chain[k+1])
      );
    end
    assign frame_o[l] = {addr_sel[l], hit_sel[l], chain[ADDR_W]};

    assert_parity_even_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(frame_o[l]) % 2) == 0);
    assert_idle_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_o[l][1] |-> frame_o[l] == '0);
    if (l > 0) begin : g_order
      assert_link_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_o[l][1] |-> (frame_o[l-1][1] &&
                           frame_o[l][FRAME_W-1:2] > frame_o[l-1][FRAME_W-1:2]));
    end
  end
endmodule

// File: rtl/hitser_shift.sv
module hitser_shift #(
  parameter int unsigned N_LINKS = 2,
  parameter int unsigned FRAME_W = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  logic [N_LINKS-1:0][FRAME_W-1:0] frame_i,
  output logic [N_LINKS-1:0]              link_o
);
  for (genvar l = 0; l < N_LINKS; l++) begin : g_sr
    logic [FRAME_W-1:0] sr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sr_q <= '0;
      else if (load_i) sr_q <= frame_i[l];
      else             sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
    end

    assign link_o[l] = sr_q[FRAME_W-1];

    assert_load_msb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> link_o[l] == $past(frame_i[l][FRAME_W-1]));
  end
endmodule

// File: rtl/hit_link_serializer.sv
module hit_link_serializer
  import hitser_pkg::*;
#(
  parameter int unsigned N_PIX   = DEF_N_PIX,
  parameter int unsigned N_LINKS = DEF_N_LINKS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PIX-1:0]   hit_i,
  output logic [N_LINKS-1:0] link_o
);
  localparam int unsigned ADDR_W  = $clog2(N_PIX);
  localparam int unsigned FRAME_W = ADDR_W + 2;

  logic                            tick;
  logic [N_PIX-1:0]                edges;
  logic [N_LINKS-1:0][FRAME_W-1:0] frames;

  hitser_phase #(.FRAME_W(FRAME_W)) i_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  hitser_edge_sync #(.N_PIX(N_PIX)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .lvl_i  (hit_i),
    .edge_o (edges)
  );

  hitser_encoder #(
    .N_PIX   (N_PIX),
    .N_LINKS (N_LINKS),
    .ADDR_W  (ADDR_W),
    .FRAME_W (FRAME_W)
  ) i_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hits_i  (edges),
    .frame_o (frames)
  );

  hitser_shift #(.N_LINKS(N_LINKS), .FRAME_W(FRAME_W)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tick),
    .frame_i (frames),
    .link_o  (link_o)
  );

  assert_reset_quiet_R8: assert property (@(posedge clk_i)
    !rst_ni |-> link_o == '0);
endmodule

// File: tb/test_hit_link_serializer.sv
module test_hit_link_serializer;
  localparam int NPIX = 64;
  localparam int NL   = 2;
  localparam int FW   = 8;
  localparam int NP   = 204;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NPIX-1:0] hit_i = '0;
  logic [NL-1:0]   link_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [NPIX-1:0] lvl [0:NP];
  string           tag [0:NP];
  logic [FW-1:0]   cap [NL];

  always #10 clk = ~clk;

  hit_link_serializer i_hit_link_serializer (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .hit_i  (hit_i),
    .link_o (link_o)
  );

  always @(posedge clk) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  function automatic logic [FW-1:0] exp_frame(input logic [NPIX-1:0] v, input int link);
    int k;
    logic [5:0] a;
    k = 0;
    exp_frame = '0;
    for (int i = 0; i < NPIX; i++) begin
      if (v[i]) begin
        if (k == link) begin
          a = 6'(i);
          exp_frame = {a, 1'b1, 1'((($countones(a) + 1) % 2))};
        end
        k++;
      end
    end
  endfunction

  task automatic check(input string t, input logic [FW-1:0] act, input logic [FW-1:0] exp, input int m, input int l);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s frame %0d link %0d: actual %b expected %b", t, m, l, act, exp);
    end
  endtask

  // deserializer: bit j of frame m appears after edge FW*m+j
  always @(negedge clk) begin
    int j, m;
    logic [NPIX-1:0] v;
    if (rst_ni && !done && cyc >= FW) begin
      j = cyc % FW;
      m = cyc / FW;
      for (int l = 0; l < NL; l++) cap[l][FW-1-j] = link_o[l];
      if (j == FW-1) begin
        // R7: frame m carries edges sampled at boundary m-1
        if (m == 1) v = '0;
        else        v = lvl[m-1] & ~lvl[m-2];
        for (int l = 0; l < NL; l++)
          check((m == 1) ? "R6 R7" : tag[m-1], cap[l], exp_frame(v, l), m, l);
        if (m == NP + 1) done = 1'b1;
      end
    end
  end

  initial begin
    int p;
    lvl[0] = '0;
    tag[0] = "R6";
    p = 1;
    for (int i = 0; i < NPIX; i++) begin
      lvl[p] = NPIX'(1) << i;      tag[p] = "R2 R3 R9"; p++;
      lvl[p] = '0;                 tag[p] = "R6";       p++;
    end
    for (int i = 0; i < NPIX/2; i++) begin
      lvl[p] = (NPIX'(1) << i) | (NPIX'(1) << (NPIX-1-i)); tag[p] = "R4"; p++;
      lvl[p] = '0;                 tag[p] = "R6";       p++;
    end
    lvl[p] = '1;                   tag[p] = "R5";       p++;
    lvl[p] = '0;                   tag[p] = "R5";       p++;
    lvl[p] = (NPIX'(1) << 40) | (NPIX'(1) << 9) | (NPIX'(1) << 5); tag[p] = "R5"; p++;
    lvl[p] = '0;                   tag[p] = "R5";       p++;
    for (int r = 0; r < 3; r++) begin
      lvl[p] = NPIX'(1) << 7;      tag[p] = "R1";       p++;
    end
    lvl[p] = '0;                   tag[p] = "R1";       p++;
    lvl[p] = NPIX'(1) << 7;        tag[p] = "R1";       p++;
    lvl[p] = (NPIX'(1) << 7) | (NPIX'(1) << 3); tag[p] = "R1"; p++;
    lvl[p] = '0;                   tag[p] = "R1";       p++;
    lvl[p] = '0;                   tag[p] = "R6";

    repeat (3) @(negedge clk);
    checks++;
    if (link_o !== '0) begin
      errors++;
      $display("FAIL R8 reset: actual %b expected 00", link_o);
    end
    rst_ni = 1'b1;

    fork
      begin
        for (int s = 1; s <= NP; s++) begin
          do @(negedge clk); while (cyc != FW*s - 6);
          hit_i = lvl[s];
        end
        wait (done);
      end
      begin
        repeat (30000) @(posedge clk);
      end
    join_any

    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual hung expected %0d frames", NP + 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule